// File: doc/BRIEF.md
# Timer Interrupt Flag Register

This block holds the four interrupt flags of a 16-bit timer/counter: overflow, compare channel A, compare channel B and capture. Each flag is sticky. It is set by an event from the timer and stays set until it is cleared. Two things clear a flag. A per-flag acknowledge pulse arrives when the interrupt controller runs that flag's vector. Software also clears a flag by writing a one to its bit position through the bus write port.

The compare flags come from comparators inside the block. Each comparator checks the counter against its compare value. The flag is latched on the clock edge that closes the cycle in which they are equal. Force-compare strobes enter the block but never set a flag. The capture flag has two sources, and a mode input picks one. In normal use the source is the external capture event. When the capture register serves as the counter's TOP, the source is the TOP-reached strobe. The overflow flag follows a single strobe, which is produced outside the block.

The flags appear in an 8-bit read value, and the unused bits read as zero. Each flag also drives an interrupt request, which is gated by its own enable bit.

Top module: `timer_irq_flags`

## Requirements
- R1: After reset `rd_data_o`, `flags_o` and `irq_o` are all zero.
- R2: When `cnt_i` equals `ocr_a_i` (or `ocr_b_i`) during a cycle, the compare flag is set at the clock edge that ends that cycle, and not before. Channel A is read bit 1 and flag index 1. Channel B is read bit 2 and flag index 2.
- R3: A pulse on `force_i[0]` (channel A) or `force_i[1]` (channel B) without a counter match leaves both compare flags clear.
- R4: With `icr_top_mode_i` = 0, `capt_evt_i` sets the capture flag (read bit 5, flag index 3) on the next edge, and `top_hit_i` has no effect on it.
- R5: With `icr_top_mode_i` = 1, `top_hit_i` sets the capture flag on the next edge, and `capt_evt_i` has no effect on it.
- R6: `ovf_i` sets the overflow flag (read bit 0, flag index 0) on the next edge.
- R7: A pulse on `ack_i[k]` clears flag index k on the next edge and leaves the other flags unchanged.
- R8: A write with `wr_en_i` high clears each flag whose read bit is one in `wr_data_i` and leaves the flags whose bits are zero. Bits 7:6 and 4:3 always read zero, and writing ones to them has no effect.
- R9: When a set event and a clear (acknowledge or write-one) hit the same flag in the same cycle, the flag ends up set.
- R10: `irq_o[k]` equals `flags_o[k] & irq_en_i[k]` at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_i | input | 16 | Current counter value |
| ocr_a_i | input | 16 | Compare value, channel A |
| ocr_b_i | input | 16 | Compare value, channel B |
| capt_evt_i | input | 1 | External capture event strobe |
| icr_top_mode_i | input | 1 | Capture register is used as TOP |
| top_hit_i | input | 1 | Counter reached TOP strobe |
| ovf_i | input | 1 | Overflow strobe |
| force_i | input | 2 | Force-compare strobes, bit 0 = A, bit 1 = B |
| ack_i | input | 4 | Vector acknowledge, one per flag index |
| wr_en_i | input | 1 | Bus write strobe |
| wr_data_i | input | 8 | Bus write data, one clears a flag |
| irq_en_i | input | 4 | Interrupt enable per flag index |
| flags_o | output | 4 | Flags by index: overflow, A, B, capture |
| rd_data_o | output | 8 | Register read value |
| irq_o | output | 4 | Interrupt request per flag index |

## Verification
The hardest situation to create is a set and a clear landing on the same flag in the same cycle. This needs a timer event and a clear to be driven together. The bench holds an overflow strobe and that flag's acknowledge high in one cycle. It then pairs a strobe with a write-one to the same bit, and pairs a counter match with the compare acknowledge. In each case the flag must survive. The bench also keeps the counter equal to the compare value for one cycle only. It reads the register before and after that cycle's closing edge, so the one-edge latency is pinned down exactly.

// File: rtl/tifr_pkg.sv
package tifr_pkg;

  // flag indices used on the per-flag vectors (ack, enable, irq, flags)
  localparam int NFLAG  = 4;
  localparam int F_OVF  = 0;
  localparam int F_CMPA = 1;
  localparam int F_CMPB = 2;
  localparam int F_CAPT = 3;
  localparam int NCMP   = 2;

  // positions of the flags in the read/write register
  localparam int REG_W    = 8;
  localparam int BIT_OVF  = 0;
  localparam int BIT_CMPA = 1;
  localparam int BIT_CMPB = 2;
  localparam int BIT_CAPT = 5;

  // place the flag vector into the register image, reserved bits zero
  function automatic logic [REG_W-1:0] pack_flags(input logic [NFLAG-1:0] f);
    logic [REG_W-1:0] r;
    r           = '0;
    r[BIT_OVF]  = f[F_OVF];
    r[BIT_CMPA] = f[F_CMPA];
    r[BIT_CMPB] = f[F_CMPB];
    r[BIT_CAPT] = f[F_CAPT];
    return r;
  endfunction

  // pick the write-one-to-clear request per flag out of the bus data
  function automatic logic [NFLAG-1:0] w1c_pick(input logic [REG_W-1:0] w);
    logic [NFLAG-1:0] c;
    c[F_OVF]  = w[BIT_OVF];
    c[F_CMPA] = w[BIT_CMPA];
    c[F_CMPB] = w[BIT_CMPB];
    c[F_CAPT] = w[BIT_CAPT];
    return c;
  endfunction

  // next state of one sticky flag: a set event beats any clear
  function automatic logic flag_next(input logic q, input logic set, input logic clr);
    return set | (q & ~clr);
  endfunction

endpackage

// File: rtl/tifr_cmp_unit.sv
module tifr_cmp_unit #(
  parameter int CNT_W = 16
) (
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] ocr_i,
  output logic             hit_o
);
  // equality during the current cycle; the flag cell latches it at the edge
  assign hit_o = (cnt_i == ocr_i);
endmodule

// File: rtl/tifr_set_mux.sv
module tifr_set_mux
  import tifr_pkg::*;
(
  input  logic [NCMP-1:0]  cmp_hit_i,
  input  logic             capt_evt_i,
  input  logic             icr_top_mode_i,
  input  logic             top_hit_i,
  input  logic             ovf_i,
  output logic             capt_src_o,
  output logic [NFLAG-1:0] set_o
);
  // capture flag source: TOP strobe when capture register is TOP, else pin event
  assign capt_src_o = icr_top_mode_i ? top_hit_i : capt_evt_i;

  always_comb begin
    set_o         = '0;
    set_o[F_OVF]  = ovf_i;
    set_o[F_CMPA] = cmp_hit_i[0];
    set_o[F_CMPB] = cmp_hit_i[1];
    set_o[F_CAPT] = capt_src_o;
  end
endmodule

// File: rtl/tifr_flag_cell.sv
module tifr_flag_cell
  import tifr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_o <= 1'b0;
    else        q_o <= flag_next(q_o, set_i, clr_i);
  end
endmodule

// File: rtl/timer_irq_flags.sv
module timer_irq_flags
  import tifr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [CNT_W-1:0]      cnt_i,
  input  logic [CNT_W-1:0]      ocr_a_i,
  input  logic [CNT_W-1:0]      ocr_b_i,
  input  logic                  capt_evt_i,
  input  logic                  icr_top_mode_i,
  input  logic                  top_hit_i,
  input  logic                  ovf_i,
  input  logic [NCMP-1:0]       force_i,
  input  logic [NFLAG-1:0]      ack_i,
  input  logic                  wr_en_i,
  input  logic [REG_W-1:0]      wr_data_i,
  input  logic [NFLAG-1:0]      irq_en_i,
  output logic [NFLAG-1:0]      flags_o,
  output logic [REG_W-1:0]      rd_data_o,
  output logic [NFLAG-1:0]      irq_o
);

  // named internal events, visible to the bound checker
  logic [NCMP-1:0]  cmp_hit;
  logic             capt_src;
  logic [NFLAG-1:0] set_vec;
  logic [NFLAG-1:0] sw_clr;
  logic [NFLAG-1:0] clr_vec;
  logic [CNT_W-1:0] ocr_arr [NCMP];

  // force strobes and reserved write bits reach no flag by definition
  logic unused_force;
  logic unused_rsvd;
  assign unused_force = ^force_i;
  assign unused_rsvd  = ^{wr_data_i[7:6], wr_data_i[4:3]};

  assign ocr_arr[0] = ocr_a_i;
  assign ocr_arr[1] = ocr_b_i;

  for (genvar c = 0; c < NCMP; c++) begin : g_cmp
    tifr_cmp_unit #(.CNT_W(CNT_W)) u_cmp (
      .cnt_i (cnt_i),
      .ocr_i (ocr_arr[c]),
      .hit_o (cmp_hit[c])
    );
  end

  tifr_set_mux u_mux (
    .cmp_hit_i      (cmp_hit),
    .capt_evt_i     (capt_evt_i),
    .icr_top_mode_i (icr_top_mode_i),
    .top_hit_i      (top_hit_i),
    .ovf_i          (ovf_i),
    .capt_src_o     (capt_src),
    .set_o          (set_vec)
  );

  assign sw_clr  = wr_en_i ? w1c_pick(wr_data_i) : '0;
  assign clr_vec = sw_clr | ack_i;

  for (genvar k = 0; k < NFLAG; k++) begin : g_flag
    tifr_flag_cell u_cell (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (set_vec[k]),
      .clr_i (clr_vec[k]),
      .q_o   (flags_o[k])
    );
  end

  assign rd_data_o = pack_flags(flags_o);
  assign irq_o     = flags_o & irq_en_i;

endmodule

// File: rtl/timer_irq_flags_chk.sv
module timer_irq_flags_chk
  import tifr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [CNT_W-1:0]      cnt_i,
  input logic [CNT_W-1:0]      ocr_a_i,
  input logic [CNT_W-1:0]      ocr_b_i,
  input logic                  capt_evt_i,
  input logic                  icr_top_mode_i,
  input logic                  top_hit_i,
  input logic                  ovf_i,
  input logic [NCMP-1:0]       force_i,
  input logic [NFLAG-1:0]      ack_i,
  input logic [NFLAG-1:0]      set_vec,
  input logic [NFLAG-1:0]      irq_en_i,
  input logic [NFLAG-1:0]      flags_o,
  input logic [REG_W-1:0]      rd_data_o,
  input logic [NFLAG-1:0]      irq_o
);

  assert_cmp_a_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_i == ocr_a_i) |=> flags_o[F_CMPA]);

  assert_cmp_b_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_i == ocr_b_i) |=> flags_o[F_CMPB]);

  assert_force_no_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (force_i[0] && cnt_i != ocr_a_i && !flags_o[F_CMPA]) |=> !flags_o[F_CMPA]);

  assert_capt_pin_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!icr_top_mode_i && capt_evt_i) |=> flags_o[F_CAPT]);

  assert_capt_top_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (icr_top_mode_i && top_hit_i) |=> flags_o[F_CAPT]);

  assert_capt_top_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (icr_top_mode_i && !top_hit_i && !flags_o[F_CAPT]) |=> !flags_o[F_CAPT]);

  assert_ovf_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_i |=> flags_o[F_OVF]);

  assert_ack_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i[F_OVF] && !ovf_i) |=> !flags_o[F_OVF]);

  assert_reserved_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data_o[7:6] == 2'b00) && (rd_data_o[4:3] == 2'b00));

  assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    set_vec[F_CAPT] |=> flags_o[F_CAPT]);

  assert_irq_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o & ~flags_o) == '0 && ((flags_o & irq_en_i) & ~irq_o) == '0);

endmodule

bind timer_irq_flags timer_irq_flags_chk #(.CNT_W(CNT_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .cnt_i          (cnt_i),
  .ocr_a_i        (ocr_a_i),
  .ocr_b_i        (ocr_b_i),
  .capt_evt_i     (capt_evt_i),
  .icr_top_mode_i (icr_top_mode_i),
  .top_hit_i      (top_hit_i),
  .ovf_i          (ovf_i),
  .force_i        (force_i),
  .ack_i          (ack_i),
  .set_vec        (set_vec),
  .irq_en_i       (irq_en_i),
  .flags_o        (flags_o),
  .rd_data_o      (rd_data_o),
  .irq_o          (irq_o)
);

// File: tb/timer_irq_flags_test.sv
`timescale 1ns/1ps
module timer_irq_flags_test;

  localparam logic [15:0] OCR_A = 16'h1234;
  localparam logic [15:0] OCR_B = 16'h2345;
  localparam logic [15:0] IDLE  = 16'hFFF0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cnt = IDLE;
  logic [15:0] ocr_a = OCR_A;
  logic [15:0] ocr_b = OCR_B;
  logic        capt = 1'b0, mode = 1'b0, top = 1'b0, ovf = 1'b0;
  logic [1:0]  frc = '0;
  logic [3:0]  ack = '0;
  logic        wr = 1'b0;
  logic [7:0]  wd = '0;
  logic [3:0]  en = '0;
  logic [3:0]  flags;
  logic [7:0]  rd;
  logic [3:0]  irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  timer_irq_flags uut (
    .clk(clk), .rst_n(rst_n), .cnt_i(cnt), .ocr_a_i(ocr_a), .ocr_b_i(ocr_b),
    .capt_evt_i(capt), .icr_top_mode_i(mode), .top_hit_i(top), .ovf_i(ovf),
    .force_i(frc), .ack_i(ack), .wr_en_i(wr), .wr_data_i(wd), .irq_en_i(en),
    .flags_o(flags), .rd_data_o(rd), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // one clock edge, then back to the falling edge where inputs change
  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    cnt = IDLE; capt = 0; top = 0; ovf = 0; frc = '0; ack = '0; wr = 0; wd = '0;
  endtask

  task automatic clear_all();
    wr = 1; wd = 8'hFF; step(); idle();
  endtask

  // sets all four flags: expected register image 0x27
  task automatic set_all();
    cnt = OCR_A; ovf = 1; capt = 1; step();
    idle(); cnt = OCR_B; step(); idle();
  endtask

  task automatic t_reset();
    chk("R1 rd_data", rd, 8'h00);
    chk("R1 flags", {4'h0, flags}, 8'h00);
    chk("R1 irq", {4'h0, irq}, 8'h00);
  endtask

  task automatic t_compare();
    cnt = OCR_A;
    chk("R2 A not before edge", rd, 8'h00);
    step(); idle();
    chk("R2 A set after edge", rd, 8'h02);
    step();
    chk("R2 A sticky", rd, 8'h02);
    cnt = OCR_B; step(); idle();
    chk("R2 B set", rd, 8'h06);
    clear_all();
  endtask

  task automatic t_force();
    frc = 2'b11; step(); idle();
    chk("R3 force no set", rd, 8'h00);
    frc = 2'b01; step(); frc = 2'b10; step(); idle();
    chk("R3 force sequence no set", rd, 8'h00);
  endtask

  task automatic t_capt_pin();
    mode = 0; top = 1; step(); idle();
    chk("R4 top ignored in pin mode", rd, 8'h00);
    capt = 1; step(); idle();
    chk("R4 pin event sets capture", rd, 8'h20);
    clear_all();
  endtask

  task automatic t_capt_top();
    mode = 1; capt = 1; step(); idle();
    chk("R5 pin ignored in top mode", rd, 8'h00);
    top = 1; step(); idle();
    chk("R5 top sets capture", rd, 8'h20);
    mode = 0; clear_all();
  endtask

  task automatic t_ovf();
    ovf = 1; step(); idle();
    chk("R6 overflow set", rd, 8'h01);
    clear_all();
  endtask

  task automatic t_ack();
    set_all();
    chk("R7 all set", rd, 8'h27);
    ack = 4'b0010; step(); idle();
    chk("R7 ack A", rd, 8'h25);
    ack = 4'b1000; step(); idle();
    chk("R7 ack capture", rd, 8'h05);
    ack = 4'b0001; step(); idle();
    chk("R7 ack overflow", rd, 8'h04);
    ack = 4'b0100; step(); idle();
    chk("R7 ack B", rd, 8'h00);
  endtask

  task automatic t_w1c();
    set_all();
    wr = 1; wd = 8'h00; step(); idle();
    chk("R8 write zero keeps", rd, 8'h27);
    wr = 1; wd = 8'hD8; step(); idle();
    chk("R8 reserved write no effect", rd, 8'h27);
    wr = 1; wd = 8'h02; step(); idle();
    chk("R8 clear A only", rd, 8'h25);
    wr = 1; wd = 8'h21; step(); idle();
    chk("R8 clear capture+ovf", rd, 8'h04);
    wd = 8'h04; step(); idle();
    chk("R8 data without strobe ignored", rd, 8'h04);
    clear_all();
    chk("R8 clear all", rd, 8'h00);
  endtask

  task automatic t_set_wins();
    ovf = 1; ack = 4'b0001; step(); idle();
    chk("R9 set beats ack", rd, 8'h01);
    ovf = 1; wr = 1; wd = 8'h01; step(); idle();
    chk("R9 set beats write", rd, 8'h01);
    wr = 1; wd = 8'h01; step(); idle();
    chk("R9 plain write clears", rd, 8'h00);
    cnt = OCR_A; ack = 4'b0010; step(); idle();
    chk("R9 match beats ack", rd, 8'h02);
    clear_all();
  endtask

  task automatic t_irq();
    set_all();
    en = 4'b0101;
    #0.1;
    chk("R10 irq masked", {4'h0, irq}, 8'h05);
    en = 4'b1111;
    #0.1;
    chk("R10 irq all", {4'h0, irq}, 8'h0F);
    clear_all();
    chk("R10 irq after clear", {4'h0, irq}, 8'h00);
    en = '0;
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    step();
    rst_n = 1;
    step();
    t_reset();
    t_compare();
    t_force();
    t_capt_pin();
    t_capt_top();
    t_ovf();
    t_ack();
    t_w1c();
    t_set_wins();
    t_irq();
    done = 1;
  end

  initial begin
    for (int i = 0; i < 20000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule